// File: doc/BRIEF.md
# Paged SRAM Write-Protection Filter

This block sits between a simple bus master and a 64 KB SRAM that is split into 64 pages of 1 KB each. Every page has one protect bit. The 64 bits are held in two 32-bit protect words that software can write. A bus write that targets a protected page never reaches the memory, and the requester gets an error response instead. Writes to unprotected pages pass through, and so do all reads.

Protect bits can only be set. Writing 0 to a bit leaves it unchanged, so a bit stays set until the block is reset. An internal erase engine drives the memory port directly and ignores the protect bits. While an erase beat is present, the bus side is held off.

A three-state response machine closes every accepted request with a response one cycle later. The states are `RSP_IDLE`, `RSP_OK` and `RSP_ERR`. The transitions are:
- Any state goes to `RSP_ERR` when a request is accepted that is a write to a protected page.
- Any state goes to `RSP_OK` when any other request is accepted.
- Any state goes to `RSP_IDLE` when no request is accepted.

Top module: `sram_page_guard`

## Requirements
- R1: After reset both protect words read back as zero and no response is pending (`rsp_valid`=0).
- R2: The page index is address bits 15:10. Pages 0–31 are held in protect word 0 (`cfg_sel`=0) and pages 32–63 in protect word 1 (`cfg_sel`=1), at bit position page mod 32.
- R3: A protect-word write ORs `cfg_wdata` into the selected word. A 0 bit never clears a set bit; only reset clears it.
- R4: `cfg_rdata` shows the protect word chosen by `cfg_sel` in the same cycle, at any time.
- R5: An accepted write to an unprotected page drives `mem_en`=1, `mem_we`=1 with the request's address and data in the same cycle. It is answered with `rsp_err`=0.
- R6: An accepted write to a protected page keeps `mem_en`=0 in that cycle and is answered with `rsp_err`=1.
- R7: An accepted read is forwarded (`mem_en`=1, `mem_we`=0) whatever the page's protect bit, and is answered with `rsp_err`=0.
- R8: While `erase_valid`=1, the memory port carries a zero-data write to `erase_addr` whatever the protect bits. `req_ready` is 0 in that cycle and no bus request is accepted.
- R9: Each accepted request (`req_valid`=1 and `req_ready`=1) gets exactly one `rsp_valid` pulse in the next cycle. There is no response without an accepted request.
- R10: A request in the same cycle as a protect-word write is judged on the protect bits as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_we | input | 1 | Protect-word write strobe |
| cfg_sel | input | 1 | Protect word select (0: pages 0–31, 1: pages 32–63) |
| cfg_wdata | input | 32 | Bits to set in the selected protect word |
| cfg_rdata | output | 32 | Selected protect word |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address in the SRAM |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request can be accepted this cycle |
| erase_valid | input | 1 | Erase engine beat present |
| erase_addr | input | 16 | Address cleared by the erase beat |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_err | output | 1 | Response is a bus error |

## Verification
The memory port, `req_ready` and `cfg_rdata` are combinational and are due in the same cycle as the stimulus that drives them. The response is due exactly one clock edge after acceptance. A protect-word write takes effect only for requests in later cycles. The bench drives inputs on the falling edge and compares every output a moment later against a reference model. That model advances its protect bits and its pending response only on the rising edge, so each result is checked in the cycle it is due.

// File: rtl/sram_page_guard_pkg.sv
package sram_page_guard_pkg;

    // Response state: which answer is presented on the bus this cycle
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_OK   = 2'd1,
        RSP_ERR  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/spg_prot_regs.sv
// Set-only protect words; only reset clears them.
module spg_prot_regs #(
    parameter int NUM_PAGES = 64,
    parameter int REG_W     = 32,
    localparam int NUM_REGS = NUM_PAGES / REG_W,
    localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output logic [NUM_PAGES-1:0] prot_bits
);

    logic [REG_W-1:0] bank_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        logic hit;
        assign hit = cfg_we && (cfg_sel == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (hit) begin
                bank_q[g] <= bank_q[g] | cfg_wdata;
            end
        end

        assign prot_bits[g*REG_W +: REG_W] = bank_q[g];
    end

    assign cfg_rdata = bank_q[cfg_sel];

endmodule

// File: rtl/spg_page_decode.sv
// Address to page index and protect lookup.
module spg_page_decode #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_LOG2 = 10,
    localparam int PAGE_W    = ADDR_W - PAGE_LOG2,
    localparam int NUM_PAGES = 1 << PAGE_W
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_PAGES-1:0] prot_bits,
    output logic                 page_prot
);

    logic [PAGE_W-1:0] page_idx;

    assign page_idx  = addr[ADDR_W-1:PAGE_LOG2];
    assign page_prot = prot_bits[page_idx];

endmodule

// File: rtl/spg_rsp_fsm.sv
// One-cycle response sequencer.
module spg_rsp_fsm
    import sram_page_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic blocked,
    output logic rsp_valid,
    output logic rsp_err
);

    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = RSP_IDLE;
        unique case (1'b1)
            accept && blocked:  state_d = RSP_ERR;
            accept && !blocked: state_d = RSP_OK;
            default:            state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
            end
            RSP_OK: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b0;
            end
            RSP_ERR: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sram_page_guard.sv
module sram_page_guard #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_LOG2 = 10,
    parameter int DATA_W    = 32,
    parameter int REG_W     = 32,
    localparam int NUM_PAGES = 1 << (ADDR_W - PAGE_LOG2),
    localparam int NUM_REGS  = NUM_PAGES / REG_W,
    localparam int SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              erase_valid,
    input  logic [ADDR_W-1:0] erase_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rsp_valid,
    output logic              rsp_err
);

    logic [NUM_PAGES-1:0] prot_bits;
    logic                 page_prot;
    logic                 accept;
    logic                 blocked;

    spg_prot_regs #(
        .NUM_PAGES (NUM_PAGES),
        .REG_W     (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .prot_bits (prot_bits)
    );

    spg_page_decode #(
        .ADDR_W    (ADDR_W),
        .PAGE_LOG2 (PAGE_LOG2)
    ) u_dec (
        .addr      (req_addr),
        .prot_bits (prot_bits),
        .page_prot (page_prot)
    );

    assign req_ready = !erase_valid;
    assign accept    = req_valid && req_ready;
    assign blocked   = accept && req_write && page_prot;

    // Erase has the memory port; otherwise forward unblocked requests
    always_comb begin
        if (erase_valid) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = erase_addr;
            mem_wdata = '0;
        end else begin
            mem_en    = accept && !blocked;
            mem_we    = req_write;
            mem_addr  = req_addr;
            mem_wdata = req_wdata;
        end
    end

    spg_rsp_fsm u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .blocked   (blocked),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err)
    );

endmodule

// File: rtl/sram_page_guard_chk.sv
module sram_page_guard_chk #(
    parameter int NUM_PAGES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic                 erase_valid,
    input logic                 mem_en,
    input logic                 mem_we,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [NUM_PAGES-1:0] prot_bits
);

    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R9

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R9

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid); // R9

    AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !rsp_err); // R7

    AST_ERR_MEANS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (rsp_err == !$past(mem_en))); // R6

    AST_PROT_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((prot_bits & $past(prot_bits)) == $past(prot_bits))); // R3

    AST_ERASE_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        erase_valid |-> (mem_en && mem_we && !req_ready)); // R8

endmodule

bind sram_page_guard sram_page_guard_chk #(
    .NUM_PAGES (NUM_PAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .erase_valid (erase_valid),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .prot_bits   (prot_bits)
);

// File: tb/test_sram_page_guard.sv
`timescale 1ns/1ps
module test_sram_page_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        erase_valid = 1'b0;
    logic [15:0] erase_addr = '0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        rsp_valid, rsp_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [63:0] m_prot = '0;
    bit          m_rv = 1'b0;
    bit          m_re = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    sram_page_guard i_sram_page_guard (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_ready (req_ready),
        .erase_valid (erase_valid), .erase_addr (erase_addr),
        .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model, then advance one clock
    task automatic cycle();
        bit          acc, prot, exp_en;
        logic [5:0]  pg;
        string       tag;
        #1;
        if (rst_n) begin
            pg     = req_addr[15:10];
            prot   = m_prot[pg];
            acc    = req_valid && !erase_valid;
            exp_en = erase_valid || (acc && (!req_write || !prot));
            tag    = erase_valid ? "R8" : (!req_write ? "R7" : (prot ? "R6" : "R5"));
            chk(tag, {63'b0, mem_en}, {63'b0, exp_en});
            chk("R8", {63'b0, req_ready}, {63'b0, !erase_valid});
            if (exp_en) begin
                chk(tag, {63'b0, mem_we}, {63'b0, erase_valid || req_write});
                chk(tag, {48'b0, mem_addr}, {48'b0, erase_valid ? erase_addr : req_addr});
                if (erase_valid || req_write)
                    chk(tag, {32'b0, mem_wdata}, {32'b0, erase_valid ? 32'h0 : req_wdata});
            end
            chk("R9", {63'b0, rsp_valid}, {63'b0, m_rv});
            chk(m_re ? "R6" : "R9", {63'b0, rsp_err}, {63'b0, m_re});
            chk("R4", {32'b0, cfg_rdata}, {32'b0, cfg_sel[0] ? m_prot[63:32] : m_prot[31:0]});
        end
        @(posedge clk);
        if (!rst_n) begin
            m_prot = '0; m_rv = 1'b0; m_re = 1'b0;
        end else begin
            acc  = req_valid && !erase_valid;
            m_rv = acc;
            m_re = acc && req_write && m_prot[req_addr[15:10]]; // R10: old bits
            if (cfg_we) begin
                if (cfg_sel[0]) m_prot[63:32] = m_prot[63:32] | cfg_wdata;
                else            m_prot[31:0]  = m_prot[31:0]  | cfg_wdata;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 1'b0; req_valid = 1'b0; erase_valid = 1'b0;
    endtask

    task automatic bus(input bit wr, input logic [15:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    endtask

    task automatic setprot(input bit sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle(); cycle();
        rst_n = 1'b1;
        #1;
        // R1: reset state
        cfg_sel = 1'b0; #1 chk("R1", {32'b0, cfg_rdata}, 64'h0);
        cfg_sel = 1'b1; #1 chk("R1", {32'b0, cfg_rdata}, 64'h0);
        chk("R1", {63'b0, rsp_valid}, 64'h0);
        cfg_sel = 1'b0;
        cycle();

        // R5: write to unprotected page 5 passes
        bus(1, 16'h1400, 32'hDEAD_0005); cycle(); idle();
        #1 chk("R5", {63'b0, rsp_err}, 64'h0);
        cycle();

        // Protect page 5, then write is blocked and read passes
        setprot(0, 32'h0000_0020); cycle(); idle();
        bus(1, 16'h1404, 32'h1111_2222); cycle(); idle();
        #1 chk("R6", {62'b0, rsp_valid, rsp_err}, 64'h3);
        bus(0, 16'h1400, 32'h0); cycle(); idle();
        #1 chk("R7", {62'b0, rsp_valid, rsp_err}, 64'h2);

        // R3: writing zeros does not clear
        setprot(0, 32'h0); cycle(); idle();
        cfg_sel = 1'b0; #1 chk("R3", {32'b0, cfg_rdata}, 64'h20);
        cycle();

        // R2: word 1 bit 0 is page 32 (0x8000); page 31 (0x7C00) stays open
        setprot(1, 32'h0000_0001); cycle(); idle();
        bus(1, 16'h8000, 32'hA); cycle(); idle();
        #1 chk("R2", {63'b0, rsp_err}, 64'h1);
        bus(1, 16'h7C00, 32'hB); cycle(); idle();
        #1 chk("R2", {63'b0, rsp_err}, 64'h0);
        bus(1, 16'hFC00, 32'hC); cycle(); idle();
        #1 chk("R2", {63'b0, rsp_err}, 64'h0);

        // R10: same-cycle protect write does not affect the request
        setprot(0, 32'h0000_0080); bus(1, 16'h1C00, 32'h7); cycle(); idle();
        #1 chk("R10", {63'b0, rsp_err}, 64'h0);
        bus(1, 16'h1C10, 32'h8); cycle(); idle();
        #1 chk("R10", {63'b0, rsp_err}, 64'h1);

        // R8: erase of protected page while a write waits
        erase_valid = 1'b1; erase_addr = 16'h1400; bus(1, 16'h0000, 32'h9); cycle();
        erase_valid = 1'b0;
        #1 chk("R8", {63'b0, rsp_valid}, 64'h0);
        cycle(); idle();
        #1 chk("R8", {63'b0, rsp_valid}, 64'h1);
        cycle();

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            cfg_we      = ($urandom_range(0, 15) == 0);
            cfg_sel     = 1'($urandom_range(0, 1));
            cfg_wdata   = $urandom & $urandom;
            req_valid   = ($urandom_range(0, 3) != 0);
            req_write   = 1'($urandom_range(0, 1));
            req_addr    = 16'($urandom);
            req_wdata   = $urandom;
            erase_valid = ($urandom_range(0, 7) == 0);
            erase_addr  = 16'($urandom);
            cycle();
        end
        idle();

        // R1: reset clears set bits
        rst_n = 1'b0; cycle(); rst_n = 1'b1;
        cfg_sel = 1'b0; #1 chk("R1", {32'b0, cfg_rdata}, 64'h0);
        cfg_sel = 1'b1; #1 chk("R1", {32'b0, cfg_rdata}, 64'h0);
        cycle(); cycle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule